// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Beat Order

This block supplies the word address for a four-beat burst into a synchronous memory. A load captures a full address from the request bus. Each later advance steps only the two lowest address bits, and the upper bits keep the value they had at the load. The step pattern comes from a static order input. In interleaved order the low bits are the starting low bits XOR a beat count. In linear order they are the starting low bits plus the beat count, modulo four. In both orders the sequence wraps inside its aligned four-word group.

An active-low clock enable masks the whole block: while it is high, nothing is loaded and the burst does not move on. A synchronous active-high reset clears the stored address and the beat count. The output is driven by combinational logic from the stored base address and the beat count. A load or an advance therefore shows on `word_addr` just after the clock edge that samples it.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the stored address and the beat count become zero, so `word_addr` reads 0 after that edge.
- R2: With `hold_n`=0 and `adv_n`=0 at a rising edge, `word_addr` equals the `req_addr` value sampled at that edge.
- R3: With `hold_n`=0 and `adv_n`=1 at a rising edge (an advance), the value on `req_addr` has no effect on `word_addr`.
- R4: With `order_il`=1 (interleaved), after k advances since the last load the low two bits equal start XOR k. From 01 this gives 01,00,11,10, and from 10 it gives 10,11,00,01.
- R5: With `order_il`=0 (linear), after k advances the low two bits equal (start + k) mod 4. From 01 this gives 01,10,11,00, and from 11 it gives 11,00,01,10.
- R6: Bits [ADDR_W-1:2] of `word_addr` never change on an advance, including the linear step from 11 to 00.
- R7: After four advances the low bits are back at the starting low bits, and the sequence then repeats.
- R8: With `hold_n`=1 at a rising edge, `word_addr` keeps its value whatever `adv_n` and `req_addr` carry.
- R9: A load in the middle of a burst restarts the beat count, so the new address appears unchanged and the next advance is its first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_n | input | 1 | Clock enable, active low; high holds all state |
| adv_n | input | 1 | 0 = load a new address, 1 = advance one beat |
| order_il | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| req_addr | input | ADDR_W | Address captured on a load |
| word_addr | output | ADDR_W | Current word address |

## Verification
The assertions assume that `order_il` is static while a burst is running. It may change only while the block is in reset or just before a fresh load. Otherwise the low bits would change with no clock edge, and the stability properties would not relate to anything real. The bench changes the order select only on cycles that end with a load. It drives every input at the falling edge, so the values are steady when the rising edge samples them, and it compares `word_addr` after the falling edge with an integer model of base address and beat count.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    // Operation applied at the next rising edge
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_ADV  = 2'd2
    } seq_op_e;

    // Static order choice
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // Default group size exponent (4-word groups)
    localparam int unsigned DEF_BEAT_W = 2;

    function automatic seq_op_e decode_op(input logic hold_n, input logic adv_n);
        if (hold_n)
            return OP_HOLD;
        else if (!adv_n)
            return OP_LOAD;
        else
            return OP_ADV;
    endfunction

endpackage

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
    import bsq_pkg::*;
#(
    parameter int unsigned BEAT_W = DEF_BEAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_op_e           op,
    output logic [BEAT_W-1:0] beat
);

    always_ff @(posedge clk) begin
        if (rst)
            beat <= '0;
        else begin
            case (op)
                OP_LOAD: beat <= '0;
                OP_ADV:  beat <= beat + 1'b1;
                default: beat <= beat;
            endcase
        end
    end

    // R8
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(beat));

    // R9
    beat_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |=> (beat == '0));

    // R7
    beat_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADV && beat == '1) |=> (beat == '0));

endmodule

// File: rtl/bsq_addr_reg.sv
module bsq_addr_reg
    import bsq_pkg::*;
#(
    parameter int unsigned ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_op_e           op,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] base
);

    always_ff @(posedge clk) begin
        if (rst)
            base <= '0;
        else if (op == OP_LOAD)
            base <= req_addr;
    end

    // R3
    base_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADV) |=> $stable(base));

endmodule

// File: rtl/bsq_low_step.sv
module bsq_low_step
    import bsq_pkg::*;
#(
    parameter int unsigned BEAT_W = DEF_BEAT_W
) (
    input  logic              order_il,
    input  logic [BEAT_W-1:0] start_low,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] low_out
);

    burst_order_e order;
    assign order = burst_order_e'(order_il);

    always_comb begin
        case (order)
            ORD_INTERLEAVE: low_out = start_low ^ beat;
            default:        low_out = start_low + beat;
        endcase
    end

    // R7
    always_comb begin
        if (beat == '0)
            lead_beat_chk: assert (low_out == start_low);
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bsq_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned BEAT_W = DEF_BEAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_n,
    input  logic              adv_n,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] word_addr
);

    localparam int unsigned UP_W = ADDR_W - BEAT_W;

    seq_op_e           op;
    logic [BEAT_W-1:0] beat;
    logic [ADDR_W-1:0] base;
    logic [BEAT_W-1:0] low_bits;

    assign op = decode_op(hold_n, adv_n);

    bsq_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .beat (beat)
    );

    bsq_addr_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .req_addr (req_addr),
        .base     (base)
    );

    bsq_low_step #(.BEAT_W(BEAT_W)) u_step (
        .order_il  (order_il),
        .start_low (base[BEAT_W-1:0]),
        .beat      (beat),
        .low_out   (low_bits)
    );

    generate
        if (UP_W > 0) begin : g_upper
            assign word_addr = {base[ADDR_W-1:BEAT_W], low_bits};
        end else begin : g_flat
            assign word_addr = low_bits;
        end
    endgenerate

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (word_addr == '0));

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_n && !adv_n) |=> (word_addr == $past(req_addr)));

    // R6
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_n && adv_n) |=> $stable(word_addr[ADDR_W-1:BEAT_W]));

endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

    localparam int  AW       = 18;
    localparam time CLK_HALF = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hold_n = 1'b0;
    logic          adv_n = 1'b0;
    logic          order_il = 1'b1;
    logic [AW-1:0] req_addr = '0;
    logic [AW-1:0] word_addr;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // Behavioural reference state
    int ref_base = 0;
    int ref_k    = 0;

    always #(CLK_HALF) clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) dut (
        .clk       (clk),
        .rst       (rst),
        .hold_n    (hold_n),
        .adv_n     (adv_n),
        .order_il  (order_il),
        .req_addr  (req_addr),
        .word_addr (word_addr)
    );

    function automatic int expect_addr();
        int s, lo;
        s = ref_base % 4;
        if (order_il)
            lo = s ^ ref_k;
        else
            lo = (s + ref_k) % 4;
        return (ref_base / 4) * 4 + lo;
    endfunction

    task automatic check(input string tag, input int exp_v);
        total++;
        if (int'(word_addr) != exp_v) begin
            bad++;
            $display("FAIL %s: word_addr=%h expected=%h", tag, word_addr, exp_v[AW-1:0]);
        end
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge,
    // compare after the next falling edge
    task automatic cyc(input bit r, input bit hn, input bit an, input int a, input string tag);
        rst = r; hold_n = hn; adv_n = an; req_addr = a[AW-1:0];
        @(posedge clk);
        if (r) begin
            ref_base = 0; ref_k = 0;
        end else if (!hn) begin
            if (!an) begin
                ref_base = a % (1 << AW); ref_k = 0;
            end else
                ref_k = (ref_k + 1) % 4;
        end
        @(negedge clk);
        check(tag, expect_addr());
    endtask

    int start_a;

    initial begin
        @(negedge clk);
        cyc(1, 0, 0, 18'h3ffff, "R1");
        check("R1", 0);

        // Interleaved from low bits 01
        order_il = 1'b1;
        start_a = 18'h2A5A1;
        cyc(0, 0, 0, start_a, "R2");
        cyc(0, 0, 1, 18'h15555, "R3");
        check("R4", start_a ^ 1);          // 01 -> 00
        cyc(0, 0, 1, 18'h0, "R4");
        check("R4", start_a ^ 2);          // -> 11
        cyc(0, 0, 1, 18'h3ffff, "R4");
        check("R6", (start_a / 4) * 4 + 2); // -> 10, upper kept
        cyc(0, 0, 1, 18'h1234, "R7");
        check("R7", start_a);
        // Hold: neither load nor advance
        cyc(0, 1, 0, 18'h00007, "R8");
        check("R8", start_a);
        cyc(0, 1, 1, 18'h3fff0, "R8");
        check("R8", start_a);
        cyc(0, 0, 1, 18'h0, "R4");

        // Interleaved from 10, reload mid-burst
        start_a = 18'h1C3F6;
        cyc(0, 0, 0, start_a, "R2");
        cyc(0, 0, 1, 18'h0, "R4");
        check("R4", start_a ^ 1);          // 10 -> 11
        cyc(0, 0, 1, 18'h0, "R4");
        check("R4", start_a ^ 2);          // -> 00
        start_a = 18'h00A09;
        cyc(0, 0, 0, start_a, "R9");
        check("R9", start_a);
        cyc(0, 0, 1, 18'h3ffff, "R9");
        check("R9", start_a ^ 1);

        // Linear from 01 (order changed on a load cycle)
        order_il = 1'b0;
        start_a = 18'h30005;
        cyc(0, 0, 0, start_a, "R2");
        cyc(0, 0, 1, 18'h0, "R5");
        check("R5", start_a + 1);          // 01 -> 10
        cyc(0, 0, 1, 18'h0, "R5");
        cyc(0, 0, 1, 18'h0, "R5");
        check("R6", start_a - 1);          // -> 00 without carry
        cyc(0, 0, 1, 18'h0, "R7");
        check("R7", start_a);

        // Linear from 11
        start_a = 18'h0BEEF;
        cyc(0, 0, 0, start_a, "R2");
        cyc(0, 0, 1, 18'h0, "R6");
        check("R6", start_a - 3);          // 11 -> 00
        cyc(0, 0, 1, 18'h0, "R5");
        cyc(0, 1, 1, 18'h0, "R8");
        check("R8", start_a - 2);
        cyc(0, 0, 1, 18'h0, "R5");
        cyc(0, 0, 1, 18'h0, "R7");
        cyc(0, 0, 1, 18'h0, "R7");
        check("R7", start_a - 3);

        // Reset in the middle of a burst
        cyc(1, 0, 1, 18'h3ffff, "R1");
        check("R1", 0);
        cyc(0, 0, 1, 18'h0, "R5");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_HALF * 2 * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule